// File: doc/BRIEF.md
# Inter-Processor Interrupt Destination Resolver

This block turns a 64-bit interrupt command into the set of agents that must receive it. The command arrives as two 32-bit words. Writing the low word starts a resolution. The high word carries the 8-bit destination. Each of the N agents supplies its physical ID, its logical ID, a 2-bit logical format code and an enable bit. The block compares the destination against every agent at once. It then emits a one-cycle pulse that carries the target bitmap and the command's vector, delivery mode, level and trigger bits.

For lowest-priority delivery (mode 3'b001) the match set is narrowed to a single enabled agent. The choice is round-robin: the search starts at the agent after the previous winner and wraps around. Delivering the interrupt into each agent is left to the logic downstream.

Control is a three-state machine:
- **IDLE** accepts command writes. A low-word write moves it to **MATCH**.
- **MATCH** registers the match set and always moves to **PICK**.
- **PICK** emits the result and always returns to **IDLE**.

Top module: `ipi_dest_resolver`

## Requirements
- R1: After reset, both stored command words are zero. In IDLE, a high-word write stores bits [31:24] and zeroes bits [23:0]. In IDLE, a low-word write stores the word with bit 12 forced to 0 and also captures `src_idx` as the sender.
- R2: A low-word write sampled at clock edge t gives `out_valid` high for exactly the one cycle after edge t+2, and low after edges t+1 and t+3.
- R3: With the result, `out_vector` = low[7:0], `out_dmode` = low[10:8], `out_level` = low[14] and `out_trig` = low[15] of the stored low word.
- R4: With shorthand 0 (low[19:18] = 0) and physical mode (low[11] = 0), agent i is targeted when the destination (high[31:24]) is 8'hFF or equals its physical ID.
- R5: With shorthand 0 and logical mode (low[11] = 1), an agent with format code 0 (flat) is targeted when (logical ID & destination) != 0.
- R6: In logical mode, an agent with format code 1 (cluster) is targeted when the upper nibbles of its logical ID and the destination are equal and the lower nibbles share a set bit. Format codes 2 and 3 never match.
- R7: The shorthand overrides the destination:
  - 1 targets only the sender.
  - 2 targets every agent.
  - 3 targets every agent except the sender.
- R8: In lowest-priority mode (low[10:8] = 3'b001), the bitmap holds at most one bit. It marks the first agent that both matches and is enabled, searching upward from the previous winner plus one and wrapping. That agent becomes the new previous winner. After reset the previous winner is N-1.
- R9: In lowest-priority mode with no enabled match, the pulse still occurs, the bitmap is zero, and the previous winner is unchanged.
- R10: In every mode other than lowest-priority, the bitmap is the full match set regardless of the enable bits.
- R11: Writes to either command word while in MATCH or PICK are ignored. They change neither the stored words nor the number of result pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_lo_we | input | 1 | Low command word write strobe (starts a resolution) |
| cmd_lo | input | 32 | Low command word |
| cmd_hi_we | input | 1 | High command word write strobe |
| cmd_hi | input | 32 | High command word |
| src_idx | input | IDX_W | Index of the sending agent |
| agent_phys_id | input | 8*N_AGENTS | Physical IDs, agent i at [8i+7:8i] |
| agent_log_id | input | 8*N_AGENTS | Logical IDs, agent i at [8i+7:8i] |
| agent_fmt | input | 2*N_AGENTS | Logical format codes (0 flat, 1 cluster, 2/3 none) |
| agent_en | input | N_AGENTS | Agent enabled for lowest-priority selection |
| cmd_lo_q | output | 32 | Stored low command word |
| cmd_hi_q | output | 32 | Stored high command word |
| out_valid | output | 1 | One-cycle result pulse |
| out_targets | output | N_AGENTS | Target bitmap |
| out_vector | output | 8 | Interrupt vector |
| out_dmode | output | 3 | Delivery mode |
| out_level | output | 1 | Assert level |
| out_trig | output | 1 | Trigger mode |

## Verification
Two events can fall in the same cycle: the result pulse of one command and the capture of the next low-word write. This happens because PICK returns to IDLE on the edge that raises `out_valid`. The bench provokes the overlap by driving the next lowest-priority command in the very cycle `out_valid` is high. It then checks that the second pick starts after the winner just emitted, so the round-robin pointer update and the new capture do not interfere. A second overlap is checked as well: writes held during MATCH and PICK must leave the stored words intact and produce only one pulse.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
    localparam int DEST_W = 8;

    typedef enum logic [1:0] {
        SH_NONE   = 2'd0,
        SH_SELF   = 2'd1,
        SH_ALL    = 2'd2,
        SH_OTHERS = 2'd3
    } shorthand_t;

    typedef enum logic [1:0] {
        FMT_FLAT    = 2'd0,
        FMT_CLUSTER = 2'd1
    } fmt_t;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_MATCH = 2'd1,
        S_PICK  = 2'd2
    } state_t;

    localparam logic [2:0] DM_LOWEST = 3'b001;
endpackage

// File: rtl/ipi_match_unit.sv
module ipi_match_unit
    import ipi_pkg::*;
#(
    parameter int N_AGENTS = 8,
    localparam int IDX_W = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
    input  logic [DEST_W-1:0]          dest,
    input  logic                       dest_logical,
    input  logic [1:0]                 shorthand,
    input  logic [IDX_W-1:0]           src,
    input  logic [DEST_W*N_AGENTS-1:0] phys_id,
    input  logic [DEST_W*N_AGENTS-1:0] log_id,
    input  logic [2*N_AGENTS-1:0]      fmt,
    output logic [N_AGENTS-1:0]        hit
);
    for (genvar g = 0; g < N_AGENTS; g++) begin : g_agent
        logic [DEST_W-1:0] lid;
        logic              phys_hit;
        logic              log_hit;

        assign lid      = log_id[g*DEST_W +: DEST_W];
        assign phys_hit = (dest == 8'hFF) || (dest == phys_id[g*DEST_W +: DEST_W]);

        always_comb begin
            case (fmt[2*g +: 2])
                FMT_FLAT:    log_hit = |(lid & dest);
                FMT_CLUSTER: log_hit = (lid[7:4] == dest[7:4]) && |(lid[3:0] & dest[3:0]);
                default:     log_hit = 1'b0;
            endcase
        end

        always_comb begin
            case (shorthand)
                SH_NONE:   hit[g] = dest_logical ? log_hit : phys_hit;
                SH_SELF:   hit[g] = (src == IDX_W'(g));
                SH_ALL:    hit[g] = 1'b1;
                default:   hit[g] = (src != IDX_W'(g));
            endcase
        end
    end
endmodule

// File: rtl/ipi_rr_picker.sv
module ipi_rr_picker #(
    parameter int N_AGENTS = 8,
    localparam int IDX_W = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
    input  logic [N_AGENTS-1:0] cand,
    input  logic [IDX_W-1:0]    prev,
    output logic [N_AGENTS-1:0] grant,
    output logic [IDX_W-1:0]    grant_idx,
    output logic                found
);
    int idx;

    always_comb begin
        grant     = '0;
        grant_idx = prev;
        found     = 1'b0;
        idx       = 0;
        for (int k = 1; k <= N_AGENTS; k++) begin
            idx = int'(prev) + k;
            if (idx >= N_AGENTS) idx = idx - N_AGENTS;
            if (!found && cand[idx]) begin
                grant[idx] = 1'b1;
                grant_idx  = IDX_W'(idx);
                found      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ipi_dest_resolver.sv
module ipi_dest_resolver
    import ipi_pkg::*;
#(
    parameter int N_AGENTS = 8,
    localparam int IDX_W = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_lo_we,
    input  logic [31:0]                cmd_lo,
    input  logic                       cmd_hi_we,
    input  logic [31:0]                cmd_hi,
    input  logic [IDX_W-1:0]           src_idx,
    input  logic [DEST_W*N_AGENTS-1:0] agent_phys_id,
    input  logic [DEST_W*N_AGENTS-1:0] agent_log_id,
    input  logic [2*N_AGENTS-1:0]      agent_fmt,
    input  logic [N_AGENTS-1:0]        agent_en,
    output logic [31:0]                cmd_lo_q,
    output logic [31:0]                cmd_hi_q,
    output logic                       out_valid,
    output logic [N_AGENTS-1:0]        out_targets,
    output logic [7:0]                 out_vector,
    output logic [2:0]                 out_dmode,
    output logic                       out_level,
    output logic                       out_trig
);
    state_t               state, state_nxt;
    logic                 busy;
    logic [IDX_W-1:0]     src_q;
    logic [IDX_W-1:0]     prev_q;
    logic [N_AGENTS-1:0]  match_w, match_q;
    logic [N_AGENTS-1:0]  grant;
    logic [IDX_W-1:0]     grant_idx;
    logic                 found;
    logic                 lowest;

    assign busy   = (state != S_IDLE);
    assign lowest = (cmd_lo_q[10:8] == DM_LOWEST);

    ipi_match_unit #(.N_AGENTS(N_AGENTS)) u_match (
        .dest         (cmd_hi_q[31:24]),
        .dest_logical (cmd_lo_q[11]),
        .shorthand    (cmd_lo_q[19:18]),
        .src          (src_q),
        .phys_id      (agent_phys_id),
        .log_id       (agent_log_id),
        .fmt          (agent_fmt),
        .hit          (match_w)
    );

    ipi_rr_picker #(.N_AGENTS(N_AGENTS)) u_pick (
        .cand      (match_q & agent_en),
        .prev      (prev_q),
        .grant     (grant),
        .grant_idx (grant_idx),
        .found     (found)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE:  if (cmd_lo_we) state_nxt = S_MATCH;
            S_MATCH: state_nxt = S_PICK;
            S_PICK:  state_nxt = S_IDLE;
            default: state_nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_lo_q    <= '0;
            cmd_hi_q    <= '0;
            src_q       <= '0;
            prev_q      <= IDX_W'(N_AGENTS - 1);
            match_q     <= '0;
            out_valid   <= 1'b0;
            out_targets <= '0;
            out_vector  <= '0;
            out_dmode   <= '0;
            out_level   <= 1'b0;
            out_trig    <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (cmd_hi_we) cmd_hi_q <= {cmd_hi[31:24], 24'h0};
                    if (cmd_lo_we) begin
                        cmd_lo_q <= cmd_lo & ~32'h0000_1000;
                        src_q    <= src_idx;
                    end
                end
                S_MATCH: match_q <= match_w;
                S_PICK: begin
                    out_valid   <= 1'b1;
                    out_targets <= lowest ? grant : match_q;
                    out_vector  <= cmd_lo_q[7:0];
                    out_dmode   <= cmd_lo_q[10:8];
                    out_level   <= cmd_lo_q[14];
                    out_trig    <= cmd_lo_q[15];
                    if (lowest && found) prev_q <= grant_idx;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ipi_resolver_checker.sv
module ipi_resolver_checker #(
    parameter int N_AGENTS = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                busy,
    input logic [31:0]         cmd_lo_q,
    input logic [31:0]         cmd_hi_q,
    input logic                out_valid,
    input logic [N_AGENTS-1:0] out_targets,
    input logic [2:0]          out_dmode
);
    assert_status_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_lo_q[12] && (cmd_hi_q[23:0] == 24'h0));

    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    assert_all_targets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cmd_lo_q[11:8] != 4'b0001 && cmd_lo_q[10:8] != 3'b001
         && cmd_lo_q[19:18] == 2'd2) |-> (&out_targets));

    assert_one_winner_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_dmode == 3'b001) |-> $onehot0(out_targets));

    assert_busy_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(cmd_lo_q) && $stable(cmd_hi_q)));
endmodule

bind ipi_dest_resolver ipi_resolver_checker #(.N_AGENTS(N_AGENTS)) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .cmd_lo_q    (cmd_lo_q),
    .cmd_hi_q    (cmd_hi_q),
    .out_valid   (out_valid),
    .out_targets (out_targets),
    .out_dmode   (out_dmode)
);

// File: tb/test_ipi_dest_resolver.sv
`timescale 1ns/1ps
module test_ipi_dest_resolver;
    localparam int N = 8;
    localparam int NV = 17;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_lo_we = 1'b0, cmd_hi_we = 1'b0;
    logic [31:0]  cmd_lo = '0, cmd_hi = '0;
    logic [2:0]   src_idx = '0;
    logic [8*N-1:0] agent_phys_id, agent_log_id;
    logic [2*N-1:0] agent_fmt;
    logic [N-1:0]   agent_en;
    logic [31:0]  cmd_lo_q, cmd_hi_q;
    logic         out_valid, out_level, out_trig;
    logic [N-1:0] out_targets;
    logic [7:0]   out_vector;
    logic [2:0]   out_dmode;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ipi_dest_resolver #(.N_AGENTS(N)) i_ipi_dest_resolver (.*);

    // {lo, hi, src, expected bitmap, requirement number}
    localparam logic [78:0] TBL [NV] = '{
        {32'h0000_0041, 32'h13AB_CDEF, 3'd0, 8'h08, 4'd4},  // R4 exact ID
        {32'h0000_1042, 32'hFF00_0000, 3'd0, 8'hFF, 4'd4},  // R4 broadcast
        {32'h0000_0043, 32'h5500_0000, 3'd0, 8'h00, 4'd4},  // R4 no match
        {32'h0000_C843, 32'h0500_0000, 3'd0, 8'h05, 4'd5},  // R5 flat
        {32'h0000_0844, 32'h2300_0000, 3'd0, 8'h33, 4'd6},  // R6 cluster 2
        {32'h0000_0845, 32'h3100_0000, 3'd0, 8'h41, 4'd6},  // R6 cluster 3
        {32'h0004_0047, 32'h1300_0000, 3'd5, 8'h20, 4'd7},  // R7 self
        {32'h0008_0048, 32'h1300_0000, 3'd1, 8'hFF, 4'd7},  // R7 all
        {32'h000C_0049, 32'h1300_0000, 3'd3, 8'hF7, 4'd7},  // R7 all but sender
        {32'h0000_0150, 32'hFF00_0000, 3'd0, 8'h01, 4'd8},  // R8 first after reset
        {32'h0000_0150, 32'hFF00_0000, 3'd0, 8'h02, 4'd8},
        {32'h0000_0150, 32'hFF00_0000, 3'd0, 8'h08, 4'd8},  // R8 skips disabled
        {32'h0000_0951, 32'h0500_0000, 3'd0, 8'h01, 4'd8},  // R8 wraps
        {32'h000C_0152, 32'h0500_0000, 3'd0, 8'h02, 4'd8},
        {32'h0000_0153, 32'h1200_0000, 3'd0, 8'h00, 4'd9},  // R9 only disabled match
        {32'h0000_0154, 32'hFF00_0000, 3'd0, 8'h08, 4'd8},  // R8 pointer kept by R9
        {32'h0000_0455, 32'h1200_0000, 3'd0, 8'h04, 4'd10}  // R10 disabled included
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive at a negedge, return at the negedge after edge t+2 (result visible)
    task automatic send(input logic [31:0] lo, input logic [31:0] hi, input logic [2:0] src);
        cmd_lo = lo; cmd_hi = hi; src_idx = src;
        cmd_lo_we = 1'b1; cmd_hi_we = 1'b1;
        @(negedge clk);
        cmd_lo_we = 1'b0; cmd_hi_we = 1'b0;
        chk(out_valid == 1'b0, "R2 early", 32'(out_valid), 0);
        @(negedge clk);
        chk(out_valid == 1'b0, "R2 early", 32'(out_valid), 0);
        @(negedge clk);
        chk(out_valid == 1'b1, "R2 pulse", 32'(out_valid), 1);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < N; i++) agent_phys_id[8*i +: 8] = 8'h10 + 8'(i);
        agent_log_id = {8'hFF, 8'h31, 8'h22, 8'h21, 8'h08, 8'h04, 8'h02, 8'h01};
        agent_fmt    = {2'd2, 2'd1, 2'd1, 2'd1, 2'd0, 2'd0, 2'd0, 2'd0};
        agent_en     = 8'b1111_1011;

        @(negedge clk);
        chk(out_valid == 1'b0, "R2 reset", 32'(out_valid), 0);
        chk(cmd_lo_q == 32'h0, "R1 reset lo", cmd_lo_q, 0);
        chk(cmd_hi_q == 32'h0, "R1 reset hi", cmd_hi_q, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [31:0] lo, hi;
            string rq;
            lo = TBL[i][78:47];
            hi = TBL[i][46:15];
            rq = $sformatf("R%0d vec%0d", TBL[i][3:0], i);
            send(lo, hi, TBL[i][14:12]);
            chk(out_targets == TBL[i][11:4], rq, 32'(out_targets), 32'(TBL[i][11:4]));
            chk(out_vector == lo[7:0] && out_dmode == lo[10:8] &&
                out_level == lo[14] && out_trig == lo[15], "R3 fields",
                {out_trig, out_level, out_dmode, out_vector}, {lo[15], lo[14], lo[10:8], lo[7:0]});
            chk(cmd_lo_q == (lo & ~32'h1000), "R1 lo store", cmd_lo_q, lo & ~32'h1000);
            chk(cmd_hi_q == {hi[31:24], 24'h0}, "R1 hi store", cmd_hi_q, {hi[31:24], 24'h0});
        end
        @(negedge clk);
        chk(out_valid == 1'b0, "R2 pulse end", 32'(out_valid), 0);

        // R11: writes held through MATCH and PICK are ignored
        cmd_lo = 32'h0000_0060; cmd_hi = 32'h1100_0000; src_idx = 3'd0;
        cmd_lo_we = 1'b1; cmd_hi_we = 1'b1;
        @(negedge clk);
        cmd_lo = 32'h0008_0061; cmd_hi = 32'h1700_0000;
        @(negedge clk);
        @(negedge clk);
        cmd_lo_we = 1'b0; cmd_hi_we = 1'b0;
        chk(out_valid == 1'b1, "R11 pulse", 32'(out_valid), 1);
        chk(out_targets == 8'h02, "R11 first command kept", 32'(out_targets), 32'h02);
        chk(cmd_lo_q == 32'h0000_0060, "R11 lo unchanged", cmd_lo_q, 32'h60);
        chk(cmd_hi_q == 32'h1100_0000, "R11 hi unchanged", cmd_hi_q, 32'h1100_0000);
        @(negedge clk);
        chk(out_valid == 1'b0, "R11 single pulse", 32'(out_valid), 0);
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R11 no second pulse", 32'(out_valid), 0);

        // R8: back-to-back lowest priority, next write in the pulse cycle
        send(32'h0000_0170, 32'hFF00_0000, 3'd0);
        chk(out_targets == 8'h10, "R8 after prev 3", 32'(out_targets), 32'h10);
        send(32'h0000_0171, 32'hFF00_0000, 3'd0);
        chk(out_targets == 8'h20, "R8 back-to-back", 32'(out_targets), 32'h20);

        // R8: reset restores pointer to N-1
        do_reset();
        send(32'h0000_0172, 32'hFF00_0000, 3'd0);
        chk(out_targets == 8'h01, "R8 after reset", 32'(out_targets), 32'h01);

        // R6: format code 3 matches nothing
        agent_fmt[15:14] = 2'd3;
        send(32'h0000_0873, 32'hFF00_0000, 3'd0);
        chk(out_targets == 8'h0F, "R6 format 3", 32'(out_targets), 32'h0F);

        // R9: nothing enabled, then pointer unchanged
        agent_en = 8'h00;
        send(32'h0000_0174, 32'hFF00_0000, 3'd0);
        chk(out_targets == 8'h00, "R9 empty", 32'(out_targets), 32'h00);
        agent_en = 8'hFF;
        send(32'h0000_0175, 32'hFF00_0000, 3'd0);
        chk(out_targets == 8'h02, "R9 pointer kept", 32'(out_targets), 32'h02);

        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule